// File: doc/BRIEF.md
# SMBus Clock-Low Timeout and Alert Responder

This block is the bus-management layer of a two-wire slave. It watches the sampled clock and data lines and sends a one-cycle reset pulse to the slave's byte engine in three cases: a start condition, a stop condition, or a clock line held low past the timeout limit. A timeout also drops any transfer the block itself is driving, so the bus is released.

It also drives an active-low alert line. An internal request raises the alert, and the alert stays raised until the master reads the alert response address. During that read the slave acknowledges and sends back its own 7-bit address. Several slaves may answer at once. Each one watches the data line on the bits it leaves high. A slave that sees the line low has lost to a lower address, so it stops driving and keeps its alert raised. The timeout length comes from a clock-frequency parameter and a millisecond limit (35 ms by default).

Top module: `smb_alert_guard`

## Requirements
- R1: After reset, `alert_n` is 1, `sda_pull` is 0 and `eng_rst` is 0.
- R2: A falling `sda_i` while `scl_i` is high (a start, first or repeated) gives one `eng_rst` pulse and restarts address reception.
- R3: A rising `sda_i` while `scl_i` is high (a stop) gives one `eng_rst` pulse and returns the responder to idle.
- R4: Changes on `sda_i` while `scl_i` is low give no `eng_rst` pulse.
- R5: When `scl_i` is sampled low for TOUT_CYC consecutive cycles (TOUT_CYC = CLK_HZ/1000*TOUT_MS), one `eng_rst` pulse is sent and `sda_pull` is released, even in the middle of an alert response.
- R6: A low stretch shorter than TOUT_CYC gives no pulse. The low count clears whenever `scl_i` is sampled high, so two short stretches do not add up.
- R7: A one-cycle `alert_req` drives `alert_n` low on the next cycle, and it stays low.
- R8: A read of the alert response address (byte 0x19: address 0001100, read bit 1) received while the alert is raised is acknowledged by pulling SDA low. The next byte is sent MSB first as {own_addr, 1}, and `sda_pull` is high for each 0 bit.
- R9: `alert_n` returns to 1 only after the last bit of that byte has been clocked out without losing arbitration.
- R10: The block does not acknowledge an address byte other than 0x19, nor 0x19 when no alert is raised. In that case the alert state is left unchanged.
- R11: If SDA is sampled low at a clock rise on a bit the block leaves high, the block stops driving for the rest of the byte and `alert_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled, synchronised bus clock |
| sda_i | input | 1 | Sampled, synchronised bus data |
| alert_req | input | 1 | Pulse that raises the alert |
| own_addr | input | 7 | Slave's 7-bit address |
| alert_n | output | 1 | Active-low alert line |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge and address bits) |
| eng_rst | output | 1 | One-cycle reset pulse to the byte engine |

## Verification
The bench models the data line as a wired-AND of the master, a competing slave and `sda_pull`. The returned byte is read from the bus exactly as a master would see it.

Corner cases and the faults they expose:
- **Arbitration loss on a high bit.** A competitor with a lower address wins on one bit and then sends a 1 where this block would send a 0. A design that keeps driving after losing corrupts the competitor's byte. A design that clears the alert on loss shows `alert_n` high.
- **Timeout mid-response.** The clock is parked low while the block pulls SDA. A counter that fails to fire, or fires without releasing the pull, leaves the bus held.
- **Near-miss clock stretches.** Two low stretches just under the limit, with one high sample between them, catch a counter that does not clear.
- **Edge-type checks.** A repeated start after a partial byte must restart reception. Data toggling while the clock is low must not count as a start or a stop.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  localparam int ADDR_W = 7;
  localparam logic [7:0] ARA_READ = 8'h19; // 0001100 + read bit

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_RX,
    RS_ACK_WAIT,
    RS_ACK,
    RS_TX,
    RS_TX_END,
    RS_HOLD
  } resp_state_t;
endpackage

// File: rtl/smb_bus_edges.sv
module smb_bus_edges (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_det = scl_i & scl_q &  sda_q & ~sda_i;
    stop_det  = scl_i & scl_q & ~sda_q &  sda_i;
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
  end
endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer #(
  parameter int TOUT_CYC = 1_750_000
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  output logic tout
);
  localparam int CW = $clog2(TOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TOUT_CYC);
  localparam logic [CW-1:0] LAST  = CW'(TOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tout <= 1'b0;
    end else begin
      tout <= 1'b0;
      if (scl_i) begin
        cnt <= '0;
      end else if (cnt != LIMIT) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) tout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_ara_resp.sv
module smb_ara_resp
  import smb_alert_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              tout,
  input  logic              pend,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              pull,
  output logic              win
);
  resp_state_t state;
  logic [2:0]  bitc;
  logic [7:0]  sh;
  logic [7:0]  tx;
  logic [7:0]  rx_byte;
  logic        lose;

  always_comb begin
    rx_byte = {sh[6:0], sda_i};
    lose    = tx[bitc] & ~sda_i;
    win     = (state == RS_TX) & scl_rise & (bitc == 3'd0) & ~lose & ~tout;
  end

  always_ff @(posedge clk) begin
    if (rst || tout || stop_det) begin
      state <= RS_IDLE;
      pull  <= 1'b0;
      bitc  <= '0;
      sh    <= '0;
      tx    <= '1;
    end else if (start_det) begin
      state <= RS_RX;
      pull  <= 1'b0;
      bitc  <= '0;
    end else begin
      case (state)
        RS_RX: if (scl_rise) begin
          sh <= rx_byte;
          if (bitc == 3'd7)
            state <= (rx_byte == ARA_READ && pend) ? RS_ACK_WAIT : RS_HOLD;
          else
            bitc <= bitc + 1'b1;
        end
        RS_ACK_WAIT: if (scl_fall) begin
          pull  <= 1'b1;
          state <= RS_ACK;
        end
        RS_ACK: if (scl_fall) begin
          tx    <= {own_addr, 1'b1};
          pull  <= ~own_addr[ADDR_W-1];
          bitc  <= 3'd7;
          state <= RS_TX;
        end
        RS_TX: begin
          if (scl_rise) begin
            if (lose) begin
              pull  <= 1'b0;
              state <= RS_HOLD;
            end else if (bitc == 3'd0) begin
              state <= RS_TX_END;
            end
          end else if (scl_fall) begin
            bitc <= bitc - 1'b1;
            pull <= ~tx[bitc - 1'b1];
          end
        end
        RS_TX_END: if (scl_fall) begin
          pull  <= 1'b0;
          state <= RS_HOLD;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_alert_guard.sv
module smb_alert_guard
  import smb_alert_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TOUT_MS = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              alert_req,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              alert_n,
  output logic              sda_pull,
  output logic              eng_rst
);
  localparam int TOUT_CYC = CLK_HZ / 1000 * TOUT_MS;

  logic start_det, stop_det, scl_rise, scl_fall, tout, win;

  smb_bus_edges u_edges (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  smb_low_timer #(.TOUT_CYC(TOUT_CYC)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_i),
    .tout  (tout)
  );

  smb_ara_resp u_resp (
    .clk       (clk),
    .rst       (rst),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .tout      (tout),
    .pend      (~alert_n),
    .own_addr  (own_addr),
    .pull      (sda_pull),
    .win       (win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_n <= 1'b1;
      eng_rst <= 1'b0;
    end else begin
      eng_rst <= start_det | stop_det | tout;
      if (alert_req)  alert_n <= 1'b0;
      else if (win)   alert_n <= 1'b1;
    end
  end
endmodule

// File: rtl/smb_alert_guard_chk.sv
module smb_alert_guard_chk #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TOUT_MS = 35
) (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_i,
  input logic alert_req,
  input logic alert_n,
  input logic sda_pull,
  input logic eng_rst
);
  localparam int TOUT_CYC = CLK_HZ / 1000 * TOUT_MS;

  int lowcnt;
  always_ff @(posedge clk) begin
    if (rst || scl_i) lowcnt <= 0;
    else if (lowcnt < TOUT_CYC) lowcnt <= lowcnt + 1;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> eng_rst);

  p_stop_r3: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> eng_rst);

  p_timeout_r5: assert property (@(posedge clk) disable iff (rst)
    (!scl_i && lowcnt == TOUT_CYC - 1) |-> ##2 eng_rst);

  p_alert_set_r7: assert property (@(posedge clk) disable iff (rst)
    alert_req |=> !alert_n);

  p_pull_on_low_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !$past(scl_i));

  p_clear_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_n) |-> $past(scl_i) && !$past(alert_req));
endmodule

bind smb_alert_guard smb_alert_guard_chk #(.CLK_HZ(CLK_HZ), .TOUT_MS(TOUT_MS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_i     (sda_i),
  .alert_req (alert_req),
  .alert_n   (alert_n),
  .sda_pull  (sda_pull),
  .eng_rst   (eng_rst)
);

// File: tb/smb_alert_guard_tb_top.sv
module smb_alert_guard_tb_top;
  localparam int CLK_HZ  = 10_000;
  localparam int TOUT_MS = 35;
  localparam int TOUT    = CLK_HZ / 1000 * TOUT_MS;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, m_sda = 1'b1, o_sda = 1'b1;
  logic alert_req = 1'b0;
  logic alert_n, sda_pull, eng_rst;
  logic bus_sda;
  int   total = 0, bad = 0, pulses = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  assign bus_sda = m_sda & o_sda & ~sda_pull;

  smb_alert_guard #(.CLK_HZ(CLK_HZ), .TOUT_MS(TOUT_MS)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_m),
    .sda_i     (bus_sda),
    .alert_req (alert_req),
    .own_addr  (OWN),
    .alert_n   (alert_n),
    .sda_pull  (sda_pull),
    .eng_rst   (eng_rst)
  );

  always @(negedge clk) if (!rst && eng_rst) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic m, input logic o, output logic got);
    @(negedge clk) scl_m = 1'b0;
    wt(3); m_sda = m; o_sda = o;
    wt(3); scl_m = 1'b1;
    wt(3); got = bus_sda;
    wt(3);
  endtask

  task automatic xbyte(input logic [7:0] m, input logic [7:0] o, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) xbit(m[i], o[i], got[i]);
  endtask

  task automatic gen_start();
    @(negedge clk) scl_m = 1'b0;
    wt(3); m_sda = 1'b1; o_sda = 1'b1;
    wt(3); scl_m = 1'b1;
    wt(3); m_sda = 1'b0;
    wt(3);
  endtask

  task automatic gen_stop();
    @(negedge clk) scl_m = 1'b0;
    wt(3); m_sda = 1'b0; o_sda = 1'b1;
    wt(3); scl_m = 1'b1;
    wt(3); m_sda = 1'b1;
    wt(3);
  endtask

  // alert-response read: address byte, ack, one data byte, master NACK, stop
  task automatic ara_read(input logic [7:0] addr, input logic [7:0] comp,
                          output logic ack, output logic [7:0] data);
    logic [7:0] dmy;
    logic       nk;
    gen_start();
    xbyte(addr, 8'hFF, dmy);
    xbit(1'b1, 1'b1, ack);
    if (ack == 1'b0) xbyte(8'hFF, comp, data);
    else data = 8'hFF;
    xbit(1'b1, 1'b1, nk);
    gen_stop();
  endtask

  task automatic t_reset();
    chk("R1 alert_n", alert_n, 1'b1);
    chk("R1 sda_pull", sda_pull, 1'b0);
    chk("R1 eng_rst", eng_rst, 1'b0);
  endtask

  task automatic t_start_stop();
    int p0 = pulses;
    gen_start();
    chk("R2 start pulse", pulses, p0 + 1);
    gen_stop();
    chk("R3 stop pulse", pulses, p0 + 2);
  endtask

  task automatic t_sda_while_low();
    int p0 = pulses;
    @(negedge clk) scl_m = 1'b0;
    for (int i = 0; i < 4; i++) begin wt(2); m_sda = ~m_sda; end
    wt(2); m_sda = 1'b1;
    wt(2); scl_m = 1'b1;
    wt(4);
    chk("R4 no pulse on low-clock sda toggles", pulses, p0);
  endtask

  task automatic t_short_low();
    int p0 = pulses;
    @(negedge clk) scl_m = 1'b0;
    wt(TOUT - 5); scl_m = 1'b1;
    wt(1); scl_m = 1'b0;
    wt(TOUT - 5); scl_m = 1'b1;
    wt(5);
    chk("R6 no timeout on short stretches", pulses, p0);
  endtask

  task automatic t_alert_set();
    @(negedge clk) alert_req = 1'b1;
    @(negedge clk) alert_req = 1'b0;
    chk("R7 alert raised", alert_n, 1'b0);
    wt(20);
    chk("R7 alert held", alert_n, 1'b0);
  endtask

  task automatic t_wrong_addr();
    logic ack;
    logic [7:0] d;
    ara_read(8'hA1, 8'hFF, ack, d);
    chk("R10 no ack for other address", ack, 1'b1);
    chk("R10 alert unchanged", alert_n, 1'b0);
  endtask

  task automatic t_timeout();
    logic [7:0] dmy;
    logic ack;
    int p0;
    gen_start();
    xbyte(8'h19, 8'hFF, dmy);
    xbit(1'b1, 1'b1, ack);
    chk("R8 ack before timeout", ack, 1'b0);
    p0 = pulses;
    @(negedge clk) scl_m = 1'b0;
    wt(3); m_sda = 1'b1;
    wt(6);
    chk("R8 first address bit driven low", sda_pull, 1'b1);
    wt(TOUT + 10);
    chk("R5 timeout pulse", pulses, p0 + 1);
    chk("R5 pull released", sda_pull, 1'b0);
    chk("R5 alert kept", alert_n, 1'b0);
    scl_m = 1'b1;
    wt(4);
    gen_stop();
  endtask

  task automatic t_arb_loss();
    logic ack;
    logic [7:0] d;
    ara_read(8'h19, {7'h23, 1'b1}, ack, d);
    chk("R11 ack", ack, 1'b0);
    chk("R11 bus carries winner byte", d, {7'h23, 1'b1});
    chk("R11 alert kept after loss", alert_n, 1'b0);
    chk("R11 pull released", sda_pull, 1'b0);
  endtask

  task automatic t_ara_win();
    logic ack, nk;
    logic [7:0] d;
    int p0 = pulses;
    gen_start();
    for (int i = 0; i < 3; i++) xbit(1'b0, 1'b1, nk);
    gen_start(); // repeated start restarts reception
    chk("R2 repeated start pulse", pulses, p0 + 2);
    xbyte(8'h19, 8'hFF, d);
    xbit(1'b1, 1'b1, ack);
    chk("R8 ack after repeated start", ack, 1'b0);
    xbyte(8'hFF, 8'hFF, d);
    chk("R8 returned address byte", d, {OWN, 1'b1});
    xbit(1'b1, 1'b1, nk);
    chk("R9 alert cleared", alert_n, 1'b1);
    gen_stop();
    chk("R3 responder idle after stop", sda_pull, 1'b0);
  endtask

  task automatic t_no_alert();
    logic ack;
    logic [7:0] d;
    ara_read(8'h19, 8'hFF, ack, d);
    chk("R10 no ack without alert", ack, 1'b1);
    chk("R10 alert stays clear", alert_n, 1'b1);
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(2);
    t_reset();
    t_start_stop();
    t_sda_while_low();
    t_short_low();
    t_alert_set();
    t_wrong_addr();
    t_timeout();
    t_arb_loss();
    t_ara_win();
    t_no_alert();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule